// File: doc/BRIEF.md
# Telephone Ring Frequency Validator

This block decides whether activity on a telephone line is a real ringing signal. Two comparator flags feed it. One is high while the line is above the positive threshold and the other is high while the line is below the negative threshold. The block synchronizes both flags and times the gap between alternating crossings, counted in ticks of a fine timebase. It accepts the ring frequency only when every half-period stays inside a programmable window for a programmable length of time. Line voltage steps, pulse dialing and test voltages are rejected because they do not produce alternating crossings at the right rate.

Once the frequency is accepted, the block stops checking it. It then races two timers, both counted in ticks of a coarse timebase. The ring-end timer restarts on every crossing. The validation-delay timer starts when the frequency is accepted. If the delay expires first, the ring-envelope status rises and stays high until the line has been quiet for the ring-end period. The status edges drive a sticky interrupt flag and a polarity-selectable interrupt pin. A ring-detect pin shows either the validated envelope or an unqualified one-shot that any crossing retriggers.

Top module: `ring_validator`

## Requirements
- R1: A crossing is the rising edge of a synchronized comparator flag. A crossing whose polarity repeats the previous one is ignored, so crossings of only one polarity never lead to a valid ring.
- R2: While the frequency is being measured, an alternating crossing less than `min_half` fine ticks after the previous one abandons the measurement, and status stays 0.
- R3: While the frequency is being measured, more than `max_half` fine ticks without an alternating crossing abandons the measurement, and status stays 0.
- R4: The frequency is validated after `dur_sel` coarse ticks in tolerance. `ring_status` rises after `dly_sel` more coarse ticks, provided the ring-end timeout has not expired first.
- R5: After validation, the ring-end timer counts coarse ticks since the last crossing of either polarity. Reaching `end_sel` returns the block to idle, which drops `ring_status`. If this happens before the delay expires, no valid ring is declared for that burst.
- R6: With `enable` low, the block is held idle and `ring_status` is 0 within one cycle, whatever the inputs do.
- R7: `irq_flag` sets on each rise of `ring_status`. It also sets on each fall when `both_edges` is 1. It holds until a one-cycle `irq_clr` clears it, and a set wins over a clear in the same cycle.
- R8: `irq_pin` equals `irq_flag` when `pin_active_low` is 0 and its inverse when `pin_active_low` is 1.
- R9: With `pin_src` at 0, `ring_pin` shows `ring_status`. With `pin_src` at 1, `ring_pin` is a one-shot that any crossing starts or restarts and that ends after `OS_TICKS` coarse ticks. The one-shot runs even when validation is disabled.
- R10: After reset, `ring_status`, `irq_flag` and the one-shot are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Ring validation on |
| pos_raw | input | 1 | Comparator flag: line above positive threshold (asynchronous) |
| neg_raw | input | 1 | Comparator flag: line below negative threshold (asynchronous) |
| fine_tick | input | 1 | One-cycle timebase pulse for half-period timing |
| coarse_tick | input | 1 | One-cycle timebase pulse for duration, delay, end and one-shot timing |
| min_half | input | 6 | Shortest accepted half-period, fine ticks |
| max_half | input | 6 | Longest accepted half-period, fine ticks |
| dur_sel | input | 3 | Time in tolerance before validation, coarse ticks |
| end_sel | input | 4 | Quiet time that ends a ring, coarse ticks |
| dly_sel | input | 3 | Delay from validation to valid ring, coarse ticks |
| both_edges | input | 1 | Interrupt on both status edges when 1, rising only when 0 |
| pin_active_low | input | 1 | Invert the interrupt pin |
| pin_src | input | 1 | Ring-detect pin source: 0 envelope, 1 one-shot |
| irq_clr | input | 1 | One-cycle clear of the interrupt flag |
| ring_status | output | 1 | Validated ring envelope |
| irq_flag | output | 1 | Sticky interrupt flag |
| irq_pin | output | 1 | Interrupt pin |
| ring_pin | output | 1 | Ring-detect pin |

## Verification
A comparator change reaches the state machine after three clock edges: two synchronizer flops and one edge-detect flop. `ring_status` then changes on that edge, and `irq_flag` follows one edge later. The exact times of status edges depend on where the coarse and fine tick grids fall, so the bench does not predict them to the cycle. It pushes the expected sequence of status values into a queue, and a monitor compares every change it sees on the falling edge. Level checks on the flag, the pins and the status are taken only after margins longer than the worst-case tick phase plus the three-edge latency. Those margins are derived from the timer settings.

// File: rtl/ring_validator.sv
module ring_validator #(
  parameter int FREQ_W   = 6,
  parameter int DUR_W    = 3,
  parameter int END_W    = 4,
  parameter int DLY_W    = 3,
  parameter int OS_TICKS = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              pos_raw,
  input  logic              neg_raw,
  input  logic              fine_tick,
  input  logic              coarse_tick,
  input  logic [FREQ_W-1:0] min_half,
  input  logic [FREQ_W-1:0] max_half,
  input  logic [DUR_W-1:0]  dur_sel,
  input  logic [END_W-1:0]  end_sel,
  input  logic [DLY_W-1:0]  dly_sel,
  input  logic              both_edges,
  input  logic              pin_active_low,
  input  logic              pin_src,
  input  logic              irq_clr,
  output logic              ring_status,
  output logic              irq_flag,
  output logic              irq_pin,
  output logic              ring_pin
);
  localparam int HALF_W = FREQ_W + 1;
  localparam int OS_W   = $clog2(OS_TICKS + 1);

  typedef enum logic [1:0] {S_IDLE, S_MEAS, S_WAIT, S_RING} st_t;

  st_t              state;
  logic [1:0]       pos_sy, neg_sy;
  logic             pos_d, neg_d, last_pol, status_d;
  logic [HALF_W-1:0] half_cnt;
  logic [DUR_W-1:0] dur_cnt;
  logic [END_W-1:0] end_cnt;
  logic [DLY_W-1:0] dly_cnt;
  logic [OS_W-1:0]  os_cnt;

  wire pos_x    = pos_sy[1] & ~pos_d;
  wire neg_x    = neg_sy[1] & ~neg_d;
  wire any_x    = pos_x | neg_x;
  wire x_pol    = pos_x;
  wire alt_x    = any_x & (x_pol != last_pol);
  wire too_fast = half_cnt < {1'b0, min_half};
  wire too_slow = half_cnt > {1'b0, max_half};
  wire end_hit  = end_cnt == end_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_sy <= '0;
      neg_sy <= '0;
      pos_d  <= 1'b0;
      neg_d  <= 1'b0;
    end else begin
      pos_sy <= {pos_sy[0], pos_raw};
      neg_sy <= {neg_sy[0], neg_raw};
      pos_d  <= pos_sy[1];
      neg_d  <= neg_sy[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      last_pol <= 1'b0;
      half_cnt <= '0;
      dur_cnt  <= '0;
      end_cnt  <= '0;
      dly_cnt  <= '0;
    end else if (!enable) begin
      state    <= S_IDLE;
      half_cnt <= '0;
      dur_cnt  <= '0;
      end_cnt  <= '0;
      dly_cnt  <= '0;
    end else begin
      case (state)
        S_IDLE: if (any_x) begin
          state    <= S_MEAS;
          last_pol <= x_pol;
          half_cnt <= '0;
          dur_cnt  <= '0;
        end
        S_MEAS: begin
          if (too_slow || (alt_x && too_fast)) begin
            state <= S_IDLE;
          end else if (dur_cnt == dur_sel) begin
            state   <= S_WAIT;
            end_cnt <= '0;
            dly_cnt <= '0;
          end else begin
            if (alt_x) begin
              half_cnt <= '0;
              last_pol <= x_pol;
            end else if (fine_tick) begin
              half_cnt <= half_cnt + 1'b1;
            end
            if (coarse_tick) dur_cnt <= dur_cnt + 1'b1;
          end
        end
        S_WAIT, S_RING: begin
          if (end_hit) begin
            state <= S_IDLE;
          end else begin
            if (state == S_WAIT && dly_cnt == dly_sel) state <= S_RING;
            if (any_x) end_cnt <= '0;
            else if (coarse_tick) end_cnt <= end_cnt + 1'b1;
            if (coarse_tick) dly_cnt <= dly_cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign ring_status = state == S_RING;

  wire st_rise = ring_status & ~status_d;
  wire st_fall = ~ring_status & status_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_d <= 1'b0;
      irq_flag <= 1'b0;
    end else begin
      status_d <= ring_status;
      if (st_rise || (both_edges && st_fall)) irq_flag <= 1'b1;
      else if (irq_clr) irq_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) os_cnt <= '0;
    else if (any_x) os_cnt <= OS_W'(OS_TICKS);
    else if (coarse_tick && os_cnt != '0) os_cnt <= os_cnt - 1'b1;
  end

  assign irq_pin  = irq_flag ^ pin_active_low;
  assign ring_pin = pin_src ? (os_cnt != '0) : ring_status;
endmodule

// File: rtl/ring_validator_chk.sv
module ring_validator_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic both_edges,
  input logic pin_active_low,
  input logic pin_src,
  input logic irq_clr,
  input logic ring_status,
  input logic irq_flag,
  input logic irq_pin,
  input logic ring_pin
);
  assert_disable_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !ring_status);

  assert_rise_sets_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ring_status) |=> irq_flag);

  assert_clear_works_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && $stable(ring_status)) |=> !irq_flag);

  assert_fall_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!both_edges && $fell(ring_status) && !irq_clr) |=> $stable(irq_flag));

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !irq_clr) |=> irq_flag);

  assert_pin_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(pin_active_low) && $changed(irq_pin)) |-> $changed(irq_flag));

  assert_env_pin_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!pin_src && ring_status) |-> ring_pin);
endmodule

bind ring_validator ring_validator_chk chk_i (.*);

// File: tb/ring_validator_tb_top.sv
module ring_validator_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int OS_T = 8;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0;
  logic pos_raw = 1'b0, neg_raw = 1'b0, fine_tick = 1'b0, coarse_tick = 1'b0;
  logic [5:0] min_half = 6'd5, max_half = 6'd12;
  logic [2:0] dur_sel = 3'd5, dly_sel = 3'd2;
  logic [3:0] end_sel = 4'd4;
  logic both_edges = 1'b0, pin_active_low = 1'b0, pin_src = 1'b0, irq_clr = 1'b0;
  logic ring_status, irq_flag, irq_pin, ring_pin;

  int checks = 0, errors = 0, cyc = 0;
  bit finished = 1'b0;
  logic exp_q[$];
  logic prev_st = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ring_validator #(.OS_TICKS(OS_T)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .pos_raw(pos_raw), .neg_raw(neg_raw),
    .fine_tick(fine_tick), .coarse_tick(coarse_tick), .min_half(min_half),
    .max_half(max_half), .dur_sel(dur_sel), .end_sel(end_sel), .dly_sel(dly_sel),
    .both_edges(both_edges), .pin_active_low(pin_active_low), .pin_src(pin_src),
    .irq_clr(irq_clr), .ring_status(ring_status), .irq_flag(irq_flag),
    .irq_pin(irq_pin), .ring_pin(ring_pin));

  always @(negedge clk) begin
    cyc <= cyc + 1;
    fine_tick   <= (cyc % 4) == 0;
    coarse_tick <= (cyc % 16) == 0;
  end

  always @(negedge clk) if (rst_n) begin
    if (ring_status !== prev_st) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R4/R5 unexpected status change: actual %0b expected %0b", ring_status, prev_st);
      end else begin
        logic e;
        e = exp_q.pop_front();
        if (ring_status !== e) begin
          errors++;
          $display("FAIL R4/R5 status sequence: actual %0b expected %0b", ring_status, e);
        end
      end
      prev_st = ring_status;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic xing(input bit pol);
    if (pol) pos_raw = 1'b1; else neg_raw = 1'b1;
    repeat (4) @(negedge clk);
    pos_raw = 1'b0;
    neg_raw = 1'b0;
  endtask

  task automatic burst(input int n, input int per, input bit alt);
    for (int i = 0; i < n; i++) begin
      xing(alt ? (i % 2 == 0) : 1'b1);
      repeat (per - 4) @(negedge clk);
    end
  endtask

  task automatic pulse_clr();
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 status", ring_status, 0);
    chk("R10 flag", irq_flag, 0);
    chk("R10 irq_pin", irq_pin, 0);
    rst_n = 1'b1;
    enable = 1'b1;
    repeat (5) @(negedge clk);
    chk("R10 ring_pin", ring_pin, 0);

    exp_q.push_back(1'b1);
    exp_q.push_back(1'b0);
    burst(16, 32, 1'b1);
    chk("R4 valid burst status", ring_status, 1);
    chk("R7 flag on rise", irq_flag, 1);
    chk("R8 pin high polarity", irq_pin, 1);
    pin_active_low = 1'b1;
    @(negedge clk);
    chk("R8 pin low polarity", irq_pin, 0);
    pin_active_low = 1'b0;
    pulse_clr();
    chk("R7 cleared", irq_flag, 0);
    repeat (120) @(negedge clk);
    chk("R5 ended after quiet", ring_status, 0);
    chk("R7 fall ignored", irq_flag, 0);

    burst(16, 12, 1'b1);
    repeat (100) @(negedge clk);
    chk("R2 too fast", ring_status, 0);
    burst(8, 80, 1'b1);
    repeat (100) @(negedge clk);
    chk("R3 too slow", ring_status, 0);
    burst(16, 32, 1'b0);
    repeat (100) @(negedge clk);
    chk("R1 same polarity", ring_status, 0);
    chk("R1 no irq", irq_flag, 0);

    end_sel = 4'd1;
    dly_sel = 3'd7;
    burst(4, 32, 1'b1);
    repeat (200) @(negedge clk);
    chk("R5 end beats delay", ring_status, 0);
    end_sel = 4'd4;
    dly_sel = 3'd2;

    exp_q.push_back(1'b1);
    exp_q.push_back(1'b0);
    burst(6, 32, 1'b1);
    chk("R6 ringing before disable", ring_status, 1);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    chk("R6 disabled status", ring_status, 0);
    burst(16, 32, 1'b1);
    chk("R6 stays idle", ring_status, 0);
    repeat (120) @(negedge clk);
    enable = 1'b1;
    pulse_clr();

    both_edges = 1'b1;
    exp_q.push_back(1'b1);
    exp_q.push_back(1'b0);
    burst(10, 32, 1'b1);
    chk("R7 both rise", irq_flag, 1);
    pulse_clr();
    chk("R7 both cleared", irq_flag, 0);
    repeat (120) @(negedge clk);
    chk("R7 both fall sets", irq_flag, 1);
    both_edges = 1'b0;
    pulse_clr();

    pin_src = 1'b1;
    enable = 1'b0;
    repeat (200) @(negedge clk);
    chk("R9 one-shot idle", ring_pin, 0);
    xing(1'b1);
    repeat (60) @(negedge clk);
    chk("R9 one-shot active", ring_pin, 1);
    repeat (140) @(negedge clk);
    chk("R9 one-shot expired", ring_pin, 0);
    pin_src = 1'b0;
    enable = 1'b1;
    exp_q.push_back(1'b1);
    burst(10, 32, 1'b1);
    chk("R9 envelope on pin", ring_pin, 1);
    exp_q.push_back(1'b0);
    repeat (120) @(negedge clk);
    chk("R9 envelope pin low", ring_pin, 0);

    chk("R4 queue drained", exp_q.size(), 0);
    summary();
  end
endmodule